// File: doc/BRIEF.md
# Interrupt Status Register Controller

This block holds a 16-bit interrupt status word and raises one pending line toward the processor. Two hardware sources feed it. A primary I/O bus delivers vectored requests, and each request carries a vector that is stored in the word. An extension bus delivers a single level request. Each source has its own assert and deassert strobe. A primary-bus request is accepted only while a software-controlled enable bit is set.

Software reaches the register through a write port with two selectable views. The status view (`wr_sel` = 0) owns the enable bit and the control bits near it. The stimulus view (`wr_sel` = 1) owns the primary-bus flag and the vector field, so software can post a primary-bus interrupt with any vector. Each view replaces only its own bits and leaves all other bits unchanged. The whole word can be read at any time. The pending output is decoded from the stored word alone.

In a given cycle, the hardware strobes are applied first and the software write is applied on top of that result. Both take effect at the same clock edge.

Top module: `isr_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rd_data` is 0x0000 and `irq_pending` is low.
- R2: `irq_pending` is high exactly when bit 15 (primary flag) or bit 14 (extension flag) of `rd_data` is set. It follows the register in the same cycle.
- R3: A primary-bus assert changes no bit of the register while enable bit 10 is clear.
- R4: While bit 10 is set, a primary-bus assert sets bit 15 and loads bits 9:2 from `pbus_vector` bits 9:2. All other bits of `pbus_vector` are ignored, and all other register bits are kept.
- R5: A primary-bus deassert clears bit 15 and bits 9:2 when bit 15 is set. When bit 15 is clear, it leaves the register unchanged, including a nonzero vector field.
- R6: An extension-bus assert sets bit 14, and an extension-bus deassert clears it. Neither strobe touches any other bit.
- R7: A write with `wr_sel` = 0 replaces bits 13:10 and bit 0 (mask 0x3C01) with the same bits of `wr_data`, and keeps every other bit.
- R8: A write with `wr_sel` = 1 replaces bit 15 and bits 9:2 (mask 0x83FC) with the same bits of `wr_data`, and keeps every other bit.
- R9: When a hardware strobe and a software write occur in the same cycle, the write is applied to the result of the hardware update. On overlapping bits, the written value wins.
- R10: An assert and a deassert on the same bus in the same cycle act as the assert followed by the deassert. For the primary bus, this leaves bit 15 and bits 9:2 clear when the assert was enabled or bit 15 was already set. For the extension bus, it leaves bit 14 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pbus_assert | input | 1 | Primary-bus interrupt request strobe |
| pbus_deassert | input | 1 | Primary-bus interrupt withdraw strobe |
| pbus_vector | input | 16 | Vector supplied with a primary-bus request; bits 9:2 are used |
| xbus_assert | input | 1 | Extension-bus interrupt request strobe |
| xbus_deassert | input | 1 | Extension-bus interrupt withdraw strobe |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | Write view: 0 status, 1 stimulus |
| wr_data | input | 16 | Software write data |
| rd_data | output | 16 | Current register contents |
| irq_pending | output | 1 | Interrupt pending to the processor |

## Verification
Every strobe and write is registered once, so its effect appears on `rd_data` at the first rising edge after it is driven. `irq_pending` is combinational from the register and changes in that same cycle. The bench drives inputs at a falling edge and removes them at the next falling edge. It samples both outputs at that later falling edge, which is exactly one register stage after the stimulus. A sweep over all 64 combinations of the six control inputs, starting from varied register states, compares each result with an arithmetic model built from the requirements.

// File: rtl/isr_pkg.sv
// Package: shared widths, bit positions and write masks of the interrupt
// status word. Assumes a 16-bit word whose layout the register's users decode.
package isr_pkg;
    localparam int ISR_W   = 16;
    localparam int PRI_BIT = 15;
    localparam int EXT_BIT = 14;
    localparam int EN_BIT  = 10;
    localparam logic [ISR_W-1:0] VEC_MASK  = 16'h03FC;
    localparam logic [ISR_W-1:0] STAT_MASK = 16'h3C01;
    localparam logic [ISR_W-1:0] STIM_MASK = 16'h83FC;
    localparam logic [ISR_W-1:0] PRI_MASK  = ISR_W'(1) << PRI_BIT;

    typedef logic [ISR_W-1:0] isr_word_t;
endpackage

// File: rtl/isr_hw_update.sv
// Module: applies the hardware interrupt strobes to the current word.
// Assumes the strobes on one bus act as assert first, then deassert.
// The enable bit is taken from the word as stored, before any update.
module isr_hw_update
    import isr_pkg::*;
(
    input  isr_word_t cur,
    input  logic      pbus_assert,
    input  logic      pbus_deassert,
    input  isr_word_t pbus_vector,
    input  logic      xbus_assert,
    input  logic      xbus_deassert,
    output isr_word_t nxt
);
    isr_word_t after_pa;
    isr_word_t after_pd;
    isr_word_t after_xa;

    // Primary assert: load vector and flag when enabled.
    always_comb begin
        after_pa = cur;
        if (pbus_assert && cur[EN_BIT])
            after_pa = (cur & ~VEC_MASK) | (pbus_vector & VEC_MASK) | PRI_MASK;
    end

    // Primary deassert: clear flag and vector only while flag is set.
    always_comb begin
        after_pd = after_pa;
        if (pbus_deassert && after_pa[PRI_BIT])
            after_pd = after_pa & ~(VEC_MASK | PRI_MASK);
    end

    // Extension assert sets its level flag.
    always_comb begin
        after_xa = after_pd;
        if (xbus_assert)
            after_xa[EXT_BIT] = 1'b1;
    end

    // Extension deassert clears its level flag.
    always_comb begin
        nxt = after_xa;
        if (xbus_deassert)
            nxt[EXT_BIT] = 1'b0;
    end
endmodule

// File: rtl/isr_sw_merge.sv
// Module: merges a software write into the word under the mask of the
// selected view. Assumes it runs after the hardware update.
module isr_sw_merge
    import isr_pkg::*;
(
    input  isr_word_t base,
    input  logic      wr_en,
    input  logic      wr_sel,
    input  isr_word_t wr_data,
    output isr_word_t nxt
);
    isr_word_t mask;

    // Pick the bit mask owned by the selected view.
    always_comb mask = wr_sel ? STIM_MASK : STAT_MASK;

    // Replace the owned bits and keep the rest.
    always_comb nxt = wr_en ? ((base & ~mask) | (wr_data & mask)) : base;
endmodule

// File: rtl/isr_ctrl.sv
// Module: top of the interrupt status register controller. It holds the
// word, chains the hardware update and the software merge, and decodes
// the pending line. Assumes a synchronous active-low reset.
module isr_ctrl
    import isr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pbus_assert,
    input  logic             pbus_deassert,
    input  logic [ISR_W-1:0] pbus_vector,
    input  logic             xbus_assert,
    input  logic             xbus_deassert,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [ISR_W-1:0] wr_data,
    output logic [ISR_W-1:0] rd_data,
    output logic             irq_pending
);
    isr_word_t word_q;
    isr_word_t hw_next;
    isr_word_t word_next;

    isr_hw_update i_hw (
        .cur           (word_q),
        .pbus_assert   (pbus_assert),
        .pbus_deassert (pbus_deassert),
        .pbus_vector   (pbus_vector),
        .xbus_assert   (xbus_assert),
        .xbus_deassert (xbus_deassert),
        .nxt           (hw_next)
    );

    isr_sw_merge i_sw (
        .base    (hw_next),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .nxt     (word_next)
    );

    // Status word register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_next;
    end

    // Pending is decoded from the two source flags.
    always_comb irq_pending = word_q[PRI_BIT] | word_q[EXT_BIT];

    assign rd_data = word_q;
endmodule

// File: rtl/isr_ctrl_chk.sv
// Module: checker bound to isr_ctrl. It relates the strobes and writes of
// one cycle to the register seen in the next cycle.
module isr_ctrl_chk
    import isr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             pbus_assert,
    input logic             pbus_deassert,
    input logic [ISR_W-1:0] pbus_vector,
    input logic             xbus_assert,
    input logic             xbus_deassert,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [ISR_W-1:0] wr_data,
    input logic [ISR_W-1:0] rd_data,
    input logic             irq_pending
);
    AST_PBUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_assert && !rd_data[EN_BIT] && !pbus_deassert && !wr_en)
        |=> (rd_data[PRI_BIT] == $past(rd_data[PRI_BIT]) && rd_data[9:2] == $past(rd_data[9:2]))); // R3

    AST_PBUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pbus_assert && rd_data[EN_BIT] && !pbus_deassert && !wr_en)
        |=> (rd_data[PRI_BIT] && rd_data[9:2] == $past(pbus_vector[9:2]))); // R4

    AST_XBUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (xbus_assert && !xbus_deassert) |=> (rd_data[EXT_BIT] && irq_pending)); // R6

    AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && !pbus_assert && !pbus_deassert && !xbus_assert && !xbus_deassert)
        |=> ((rd_data & ~STAT_MASK) == $past(rd_data & ~STAT_MASK)
             && (rd_data & STAT_MASK) == $past(wr_data & STAT_MASK))); // R7

    AST_WRITE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && pbus_deassert) |=> (rd_data[PRI_BIT] == $past(wr_data[PRI_BIT]))); // R9
endmodule

bind isr_ctrl isr_ctrl_chk i_chk (.*);

// File: tb/test_isr_ctrl.sv
// Bench for isr_ctrl: directed checks, then a sweep compared to a model.
module test_isr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pbus_assert = 1'b0;
    logic        pbus_deassert = 1'b0;
    logic [15:0] pbus_vector = '0;
    logic        xbus_assert = 1'b0;
    logic        xbus_deassert = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq_pending;

    int total = 0;
    int bad = 0;
    logic [15:0] model = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    isr_ctrl i_isr_ctrl (.*);

    function automatic logic [15:0] ref_next(input logic [15:0] r, input logic pa, input logic pd,
        input logic [15:0] v, input logic xa, input logic xd, input logic we, input logic ws,
        input logic [15:0] wd);
        logic [15:0] n = r;
        if (pa && r[10]) begin n[9:2] = v[9:2]; n[15] = 1'b1; end
        if (pd && n[15]) begin n[15] = 1'b0; n[9:2] = 8'h00; end
        if (xa) n[14] = 1'b1;
        if (xd) n[14] = 1'b0;
        if (we) begin
            if (ws) n = (n & 16'h7C03) | (wd & 16'h83FC);
            else    n = (n & 16'hC3FE) | (wd & 16'h3C01);
        end
        return n;
    endfunction

    function automatic logic [15:0] step_lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check(input string tag);
        total++;
        if (rd_data !== model) begin
            bad++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, model);
        end
        total++;
        if (irq_pending !== (model[15] | model[14])) begin
            bad++;
            $display("FAIL %s irq_pending actual=%b expected=%b", tag, irq_pending, model[15] | model[14]);
        end
    endtask

    // Drive for one cycle starting at a falling edge; ends at the next falling edge.
    task automatic apply(input logic pa, input logic pd, input logic [15:0] v, input logic xa,
        input logic xd, input logic we, input logic ws, input logic [15:0] wd);
        pbus_assert = pa; pbus_deassert = pd; pbus_vector = v;
        xbus_assert = xa; xbus_deassert = xd; wr_en = we; wr_sel = ws; wr_data = wd;
        model = ref_next(model, pa, pd, v, xa, xd, we, ws, wd);
        @(negedge clk);
        pbus_assert = 0; pbus_deassert = 0; pbus_vector = '0;
        xbus_assert = 0; xbus_deassert = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = '0;
        check("R1 reset");
        // R3: primary assert while disabled
        apply(1, 0, 16'hFFFF, 0, 0, 0, 0, '0);       check("R3 disabled assert");
        // R7: status write sets enable and control bits, ignores others
        apply(0, 0, '0, 0, 0, 1, 0, 16'hFFFF);       check("R7 status write");
        // R4: enabled assert loads vector field only
        apply(1, 0, 16'hFD57, 0, 0, 0, 0, '0);       check("R4 enabled assert");
        // R2: pending from primary flag
        check("R2 pending primary");
        // R6: extension assert then deassert
        apply(0, 0, '0, 1, 0, 0, 0, '0);             check("R6 ext assert");
        apply(0, 0, '0, 0, 1, 0, 0, '0);             check("R6 ext deassert");
        // R5: deassert with flag set
        apply(0, 1, '0, 0, 0, 0, 0, '0);             check("R5 deassert clears");
        // R8: stimulus write with vector but no flag
        apply(0, 0, '0, 0, 0, 1, 1, 16'h7ABC);       check("R8 stimulus write");
        // R5: deassert with flag clear keeps vector
        apply(0, 1, '0, 0, 0, 0, 0, '0);             check("R5 deassert no-op");
        // R9: deassert and stimulus write raising flag in same cycle
        apply(0, 0, '0, 0, 0, 1, 1, 16'h8004);       check("R8 stimulus raise");
        apply(0, 1, '0, 0, 0, 1, 1, 16'h8110);       check("R9 write after hw");
        // R10: assert and deassert same cycle on each bus
        apply(1, 1, 16'h03FC, 1, 1, 0, 0, '0);       check("R10 both strobes");
        // R2: pending low with both flags clear
        check("R2 pending low");
        // Sweep all control combinations from varied states
        for (int rnd = 0; rnd < 16; rnd++) begin
            lfsr = step_lfsr(lfsr);
            apply(0, 0, '0, 0, 0, 1, 0, lfsr | ((rnd % 2 == 0) ? 16'h0400 : 16'h0000)); check("R7 sweep prime");
            lfsr = step_lfsr(lfsr);
            apply(0, 0, '0, lfsr[14], 0, 1, 1, lfsr);   check("R8 sweep prime");
            for (int c = 0; c < 64; c++) begin
                logic [15:0] v;
                logic [15:0] d;
                lfsr = step_lfsr(lfsr); v = lfsr;
                lfsr = step_lfsr(lfsr); d = lfsr;
                apply(c[0], c[1], v, c[2], c[3], c[4], c[5], d);
                check("R9 R10 sweep");
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule